// File: doc/BRIEF.md
# Bidirectional Column Driver Core

This block is the logic core of a 64-output column driver for a plasma-type display panel. Pixel data arrives four bits at a time and is pushed through four interleaved 16-stage shift chains, so that after sixteen shifts a full row of 64 bits sits in the register. Shifting can run toward the high stage numbers or toward the low ones. The two 4-bit data ports trade roles with the direction: the port at the starting end takes data in, and the port at the far end presents the end stages so a following core can take them.

A 64-bit hold register takes a copy of the shift register when its load control is high at a shift event. The output stage then drives the 64 columns from that copy. A blank control forces every column to one level, and an active-low polarity control selects either the level for blanking or straight versus inverted data.

The whole block runs on one system clock. The active-low shift clock is sampled on that clock, and each detected high-to-low transition counts as one shift event and one possible load event.

Top module: `column_driver_core`

## Requirements
- R1: A synchronous active-high reset clears all 64 shift stages and the 64-bit hold register to zero, so both port outputs read 0 and, with blank low and polarity high, every column reads 0.
- R2: The register moves exactly one step for each high-to-low transition of `shift_clk_n` seen on the system clock, in the clock after the transition is sampled. Holding `shift_clk_n` low or high for any number of cycles adds no further step.
- R3: With `dir_right` high, each step moves stage k to stage k+4 (bit k-1 to bit k+3, stage 1 at bit 0) and loads stages 1 to 4 from `port_a_i[0]` to `port_a_i[3]`. Stage 1 takes bit 0.
- R4: With `dir_right` low, each step moves stage k+4 to stage k and loads stages 61 to 64 from `port_b_i[0]` to `port_b_i[3]`. Stage 61 takes bit 0.
- R5: `port_a_o[j]` always shows stage j+1 and `port_b_o[j]` always shows stage 61+j, for j from 0 to 3, in either direction.
- R6: Input data on the port that is not selected as input by `dir_right` has no effect on the register.
- R7: When `latch_en` is high at a shift event, the hold register takes the 64 stage values present just before that event's step.
- R8: When `latch_en` is low at a shift event, or when there is no shift event, the hold register keeps its value.
- R9: When `blank` is high, all 64 columns equal `pol_n`, whatever the hold register contains.
- R10: When `blank` is low, column i equals hold bit i if `pol_n` is high and its inverse if `pol_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk_n | input | 1 | Shift clock, active low; a falling transition is one event |
| dir_right | input | 1 | 1: shift toward stage 64, port A in; 0: toward stage 1, port B in |
| latch_en | input | 1 | Load the hold register at the next shift event |
| blank | input | 1 | Force all columns to the polarity level |
| pol_n | input | 1 | Active-low polarity: 1 pass data, 0 invert data |
| port_a_i | input | 4 | Data entering stages 1 to 4 during right shifts |
| port_b_i | input | 4 | Data entering stages 61 to 64 during left shifts |
| port_a_o | output | 4 | Current contents of stages 1 to 4 |
| port_b_o | output | 4 | Current contents of stages 61 to 64 |
| col_out | output | 64 | Column drive levels |

## Verification
A misplaced or dropped stage shows up on the far-end port within sixteen shift events, because every bit must pass through that port after that many steps. The bench therefore watches both ports after every step in both directions and compares them with a model. A hold register loaded at the wrong time, or with post-step data, shows on all 64 columns in the first sample after the load event. Each blank and polarity combination appears on the columns in the same cycle that the control changes.

// File: rtl/coldrv_pkg.sv
package coldrv_pkg;

    localparam int unsigned LANES_DEF = 4;
    localparam int unsigned DEPTH_DEF = 16;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic blank;
        logic pol_n;
    } out_ctrl_t;

    typedef struct packed {
        logic       step;
        logic       load;
        shift_dir_e dir;
    } shift_cmd_t;

    // Level for one column given the held bit and output controls.
    function automatic logic column_level(input logic held, input out_ctrl_t ctl);
        logic lvl;
        if (ctl.blank) begin
            lvl = ctl.pol_n;
        end else begin
            lvl = ctl.pol_n ? held : ~held;
        end
        return lvl;
    endfunction

    // Next contents of one lane chain.
    function automatic logic [DEPTH_DEF-1:0] lane_next(
        input logic [DEPTH_DEF-1:0] cur,
        input shift_dir_e           dir,
        input logic                 head_in,
        input logic                 tail_in
    );
        logic [DEPTH_DEF-1:0] nxt;
        if (dir == DIR_RIGHT) begin
            nxt = {cur[DEPTH_DEF-2:0], head_in};
        end else begin
            nxt = {tail_in, cur[DEPTH_DEF-1:1]};
        end
        return nxt;
    endfunction

endpackage

// File: rtl/coldrv_edge_detect.sv
module coldrv_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_n,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= sig_n;
        end
    end

    assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/coldrv_shift_chain.sv
module coldrv_shift_chain
    import coldrv_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned DEPTH = DEPTH_DEF,
    localparam int unsigned W    = LANES * DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  shift_cmd_t       cmd,
    input  logic [LANES-1:0] head_in,
    input  logic [LANES-1:0] tail_in,
    output logic [LANES-1:0] head_out,
    output logic [LANES-1:0] tail_out,
    output logic [W-1:0]     stages
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [DEPTH-1:0] chain_q;
        logic [DEPTH-1:0] chain_d;

        always_comb begin
            if (cmd.dir == DIR_RIGHT) begin
                chain_d = {chain_q[DEPTH-2:0], head_in[j]};
            end else begin
                chain_d = {tail_in[j], chain_q[DEPTH-1:1]};
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else if (cmd.step) begin
                chain_q <= chain_d;
            end
        end

        assign head_out[j] = chain_q[0];
        assign tail_out[j] = chain_q[DEPTH-1];

        for (genvar s = 0; s < DEPTH; s++) begin : g_map
            assign stages[s*LANES + j] = chain_q[s];
        end
    end
endmodule

// File: rtl/coldrv_hold_reg.sv
module coldrv_hold_reg
    import coldrv_pkg::*;
#(
    parameter int unsigned W = LANES_DEF * DEPTH_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  shift_cmd_t   cmd,
    input  logic [W-1:0] stages,
    output logic [W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (cmd.step && cmd.load) begin
            held <= stages;
        end
    end
endmodule

// File: rtl/coldrv_out_stage.sv
module coldrv_out_stage
    import coldrv_pkg::*;
#(
    parameter int unsigned W = LANES_DEF * DEPTH_DEF
) (
    input  logic [W-1:0] held,
    input  out_ctrl_t    ctl,
    output logic [W-1:0] cols
);
    for (genvar i = 0; i < W; i++) begin : g_col
        assign cols[i] = column_level(held[i], ctl);
    end
endmodule

// File: rtl/column_driver_core.sv
module column_driver_core
    import coldrv_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned DEPTH = DEPTH_DEF,
    localparam int unsigned W    = LANES * DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_clk_n,
    input  logic             dir_right,
    input  logic             latch_en,
    input  logic             blank,
    input  logic             pol_n,
    input  logic [LANES-1:0] port_a_i,
    input  logic [LANES-1:0] port_b_i,
    output logic [LANES-1:0] port_a_o,
    output logic [LANES-1:0] port_b_o,
    output logic [W-1:0]     col_out
);
    logic       shift_evt;
    shift_cmd_t cmd;
    out_ctrl_t  ctl;
    logic [W-1:0] stage_vec;
    logic [W-1:0] latch_q;

    coldrv_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .sig_n (shift_clk_n),
        .fall  (shift_evt)
    );

    always_comb begin
        cmd.step = shift_evt;
        cmd.load = latch_en;
        cmd.dir  = dir_right ? DIR_RIGHT : DIR_LEFT;
        ctl.blank = blank;
        ctl.pol_n = pol_n;
    end

    coldrv_shift_chain #(.LANES(LANES), .DEPTH(DEPTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .head_in  (port_a_i),
        .tail_in  (port_b_i),
        .head_out (port_a_o),
        .tail_out (port_b_o),
        .stages   (stage_vec)
    );

    coldrv_hold_reg #(.W(W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .stages (stage_vec),
        .held   (latch_q)
    );

    coldrv_out_stage #(.W(W)) u_out (
        .held (latch_q),
        .ctl  (ctl),
        .cols (col_out)
    );
endmodule

module column_driver_core_chk #(
    parameter int unsigned LANES = 4,
    parameter int unsigned W     = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_evt,
    input logic             dir_right,
    input logic             latch_en,
    input logic             blank,
    input logic             pol_n,
    input logic [LANES-1:0] port_a_i,
    input logic [LANES-1:0] port_b_i,
    input logic [LANES-1:0] port_a_o,
    input logic [LANES-1:0] port_b_o,
    input logic [W-1:0]     latch_q,
    input logic [W-1:0]     col_out
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (port_a_o == '0 && port_b_o == '0 && latch_q == '0));

    assert_no_step_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_evt |=> ($stable(port_a_o) && $stable(port_b_o)));

    assert_right_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (shift_evt && dir_right) |=> (port_a_o == $past(port_a_i)));

    assert_left_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (shift_evt && !dir_right) |=> (port_b_o == $past(port_b_i)));

    assert_hold_keep_R8: assert property (@(posedge clk) disable iff (rst)
        !(shift_evt && latch_en) |=> $stable(latch_q));

    assert_blank_force_R9: assert property (@(posedge clk) disable iff (rst)
        blank |-> (col_out == {W{pol_n}}));

    assert_pass_data_R10: assert property (@(posedge clk) disable iff (rst)
        (!blank && pol_n) |-> (col_out == latch_q));
endmodule

bind column_driver_core column_driver_core_chk #(.LANES(LANES), .W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_evt (shift_evt),
    .dir_right (dir_right),
    .latch_en  (latch_en),
    .blank     (blank),
    .pol_n     (pol_n),
    .port_a_i  (port_a_i),
    .port_b_i  (port_b_i),
    .port_a_o  (port_a_o),
    .port_b_o  (port_b_o),
    .latch_q   (latch_q),
    .col_out   (col_out)
);

// File: tb/tb_column_driver_core.sv
module tb_column_driver_core;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int NS = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_clk_n = 1'b1;
    logic dir_right = 1'b1;
    logic latch_en = 1'b0;
    logic blank = 1'b0;
    logic pol_n = 1'b1;
    logic [NL-1:0] port_a_i = '0;
    logic [NL-1:0] port_b_i = '0;
    logic [NL-1:0] port_a_o;
    logic [NL-1:0] port_b_o;
    logic [NS-1:0] col_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    column_driver_core dut (
        .clk(clk), .rst(rst), .shift_clk_n(shift_clk_n), .dir_right(dir_right),
        .latch_en(latch_en), .blank(blank), .pol_n(pol_n),
        .port_a_i(port_a_i), .port_b_i(port_b_i),
        .port_a_o(port_a_o), .port_b_o(port_b_o), .col_out(col_out)
    );

    typedef struct {
        logic [NL-1:0] a;
        logic [NL-1:0] b;
        logic [NS-1:0] cols;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model; index k-1 is stage k.
    logic [NS-1:0] m_reg = '0;
    logic [NS-1:0] m_hold = '0;

    function automatic logic [NS-1:0] model_cols(logic [NS-1:0] h, logic b, logic p);
        logic [NS-1:0] r;
        for (int i = 0; i < NS; i++) begin
            if (b) r[i] = p;
            else if (p) r[i] = h[i];
            else r[i] = ~h[i];
        end
        return r;
    endfunction

    task automatic push_exp(string req);
        exp_t e;
        e.a = m_reg[3:0];
        e.b = m_reg[63:60];
        e.cols = model_cols(m_hold, blank, pol_n);
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic model_step(logic le);
        logic [NS-1:0] nxt;
        if (le) m_hold = m_reg;
        if (dir_right) begin
            for (int k = 60; k >= 1; k--) nxt[k+3] = m_reg[k-1];
            for (int j = 0; j < NL; j++) nxt[j] = port_a_i[j];
        end else begin
            for (int k = 1; k <= 60; k++) nxt[k-1] = m_reg[k+3];
            for (int j = 0; j < NL; j++) nxt[60+j] = port_b_i[j];
        end
        m_reg = nxt;
    endtask

    // One shift event with shift_clk_n held low for low_cycles cycles.
    task automatic do_shift(logic le, int low_cycles, string req);
        @(negedge clk);
        shift_clk_n = 1'b0;
        latch_en = le;
        model_step(le);
        repeat (low_cycles) @(negedge clk);
        shift_clk_n = 1'b1;
        latch_en = 1'b0;
        push_exp(req);
    endtask

    task automatic set_ctrl(logic b, logic p, string req);
        @(negedge clk);
        blank = b;
        pol_n = p;
        push_exp(req);
    endtask

    // Monitor: compare one expected item per posedge, a quarter period after.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (port_a_o !== e.a || port_b_o !== e.b || col_out !== e.cols) begin
                    errors++;
                    $display("FAIL %s: a=%h b=%h cols=%h expected a=%h b=%h cols=%h",
                             e.req, port_a_o, port_b_o, col_out, e.a, e.b, e.cols);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        push_exp("R1 reset state");

        // R3 / R5: right shift of 16 words, far-end port watched each step
        dir_right = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            port_a_i = 4'((i * 7 + 3) & 15);
            port_b_i = 4'(~i);          // R6: ignored in right mode
            do_shift(1'b0, 1, "R3 R5 R6 right shift");
        end

        // R2: long low phase still gives a single step
        @(negedge clk);
        port_a_i = 4'hA;
        do_shift(1'b0, 4, "R2 single step per fall");
        repeat (3) @(negedge clk);
        push_exp("R2 idle hold");

        // R7: load at an event captures pre-step contents
        @(negedge clk);
        port_a_i = 4'h5;
        do_shift(1'b1, 1, "R7 load pre-step");

        // R8: events without load leave the hold register
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            port_a_i = 4'(i + 9);
            do_shift(1'b0, 1, "R8 hold keeps value");
        end

        // R9 / R10: blank and polarity combinations
        set_ctrl(1'b0, 1'b0, "R10 inverted data");
        set_ctrl(1'b1, 1'b1, "R9 blank high level");
        set_ctrl(1'b1, 1'b0, "R9 blank low level");
        set_ctrl(1'b0, 1'b1, "R10 straight data");

        // R4 / R5 / R6: left shift of 16 words
        @(negedge clk);
        dir_right = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            port_b_i = 4'((i * 5 + 1) & 15);
            port_a_i = 4'(i ^ 6);       // R6: ignored in left mode
            do_shift(i == 15, 1, "R4 R5 R6 left shift");
        end
        set_ctrl(1'b0, 1'b0, "R10 inverted after left load");

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        m_reg = '0;
        m_hold = '0;
        @(negedge clk);
        rst = 1'b0;
        blank = 1'b0;
        pol_n = 1'b1;
        push_exp("R1 reset clears");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule